// File: doc/BRIEF.md
# Dual-Image Transactional Line Cache

This block is a small, fully associative cache that holds every line the running transaction has touched. Each such line occupies a pair of entries. One entry carries the value the line had when the transaction first reached it (the before image). The other carries the value the transaction is building (the after image). Both entries are created even when the transaction only reads the line. Ending a transaction needs no data movement. A commit drops the before images and turns the after images into ordinary cached lines. An abort does the reverse. Both take a single cycle and only rewrite the per-entry state codes.

The processor side issues one operation per cycle: transactional load, transactional store, commit, abort or validate. Each operation gets a registered response in the next cycle. When a line is not cached, the requester supplies the line's memory value on `op_fill`. A second port receives snooped reads and writes from other agents. The block refuses (NACKs) any snoop that would break the transaction's isolation, and answers in the cycle after the snoop. A pulse on `own_nack` tells the block that the transaction's own outgoing request was refused. An abort then becomes pending. The only effect of an abort is on this cache's state: software reads `abort_pending` or issues a validate, and restarts on its own.

Top module: `txc_dual_cache`

## Requirements
- R1: After reset every entry is invalid, `abort_pending` is 0, and `rsp_valid`, `snp_rsp_valid` and `evict_valid` are 0.
- R2: Every operation is answered exactly one cycle later on `rsp_valid`. Operation codes: 0 load, 1 store, 2 commit, 3 abort, 4 validate. A load of a line not yet cached returns `op_fill`. A later load of a line in the transaction returns the after image and ignores `op_fill`.
- R3: A store changes only the after image and echoes the stored value on `rsp_data`. After an abort, a load of that line returns the before image (value at first touch), not `op_fill`.
- R4: A commit with no pending abort answers `rsp_ok`=1. Every value stored in the transaction is then returned by later loads of that line, and `op_fill` is ignored.
- R5: With PAIRS lines held transactionally, a load or store of another line answers `rsp_ok`=0 and sets `abort_pending`.
- R6: A snoop write to any line in the transaction, or a snoop read to a line the transaction has stored to, gives `snp_nack`=1 one cycle later. A snoop read to a line the transaction has only read gives `snp_nack`=0, and so does any snoop to a line outside the transaction.
- R7: `own_nack` sets `abort_pending`, also for an operation in the same cycle. While an abort is pending, loads and stores answer `rsp_ok`=0 and leave the cache unchanged. A commit answers `rsp_ok`=0 and acts as an abort.
- R8: A validate answers `rsp_ok`=1 exactly when no abort is pending, and changes no state.
- R9: A snoop write to an ordinary (non-transactional) cached line drops it, so the next load of that line returns `op_fill`.
- R10: A new line takes the lowest-numbered fully invalid pair. Failing that, it takes the lowest-numbered pair holding an ordinary line. In that case `evict_valid`, `evict_addr` and `evict_data` report the dropped line in the response cycle.
- R11: An abort answers `rsp_ok`=1, clears `abort_pending` and clears all stored-to marks.
- R12: A load or store to the same line as a snoop in the same cycle answers `rsp_ok`=0. It changes no cache state and does not set `abort_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Processor operation present |
| op_kind | input | 3 | 0 load, 1 store, 2 commit, 3 abort, 4 validate |
| op_addr | input | AW | Line address of a load or store |
| op_wdata | input | DW | Store value |
| op_fill | input | DW | Memory value of the line, used when it is not cached |
| own_nack | input | 1 | The transaction's own bus request was refused |
| rsp_valid | output | 1 | Operation response present |
| rsp_ok | output | 1 | Operation succeeded (validate: no abort pending) |
| rsp_data | output | DW | Load value or stored value |
| snp_valid | input | 1 | Snooped request present |
| snp_write | input | 1 | Snooped request is a write |
| snp_addr | input | AW | Snooped line address |
| snp_rsp_valid | output | 1 | Snoop answer present |
| snp_nack | output | 1 | Snoop refused |
| evict_valid | output | 1 | An ordinary line was dropped to make room |
| evict_addr | output | AW | Address of the dropped line |
| evict_data | output | DW | Value of the dropped line |
| abort_pending | output | 1 | The running transaction must abort |

## Verification
The hardest state to reach from the ports is a cache whose pairs all hold ordinary lines left by earlier commits, with no invalid pair left, so that a new line must evict. Close behind it is a cache whose pairs are all transactional, so that one more line overflows. The directed part builds both on purpose. It commits four fresh lines, walks four more through the cache to force eviction of each committed line in turn, and then asks for a fifth. The random part uses six addresses against four pairs. Commits and aborts are sparse, so long transactions keep running into the capacity limit, and snoops and own-request refusals land on lines in every state.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {
    ST_INV  = 2'd0,
    ST_NORM = 2'd1,
    ST_OLD  = 2'd2,
    ST_NEW  = 2'd3
  } ent_st_t;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_COMMIT   = 3'd2,
    OP_ABORT    = 3'd3,
    OP_VALIDATE = 3'd4
  } op_kind_t;
endpackage

// File: rtl/txc_match.sv
// Fully associative lookup of one line address across all pairs.
module txc_match import txc_pkg::*; #(
  parameter int PAIRS = 4,
  parameter int AW    = 8,
  parameter int IW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic [AW-1:0]                addr,
  input  logic [PAIRS-1:0][AW-1:0]     tags,
  input  logic [PAIRS-1:0][1:0][1:0]   st,
  output logic                         txn_hit,
  output logic [IW-1:0]                txn_idx,
  output logic                         norm_hit,
  output logic [IW-1:0]                norm_idx,
  output logic                         norm_half
);
  logic [PAIRS-1:0] is_txn, has_norm, tag_eq;

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign is_txn[g]   = (st[g][0] == ST_OLD) || (st[g][0] == ST_NEW);
    assign has_norm[g] = (st[g][0] == ST_NORM) || (st[g][1] == ST_NORM);
    assign tag_eq[g]   = (tags[g] == addr);
  end

  always_comb begin
    txn_hit   = 1'b0;
    txn_idx   = '0;
    norm_hit  = 1'b0;
    norm_idx  = '0;
    norm_half = 1'b0;
    for (int p = PAIRS - 1; p >= 0; p--) begin
      if (is_txn[p] && tag_eq[p]) begin
        txn_hit = 1'b1;
        txn_idx = IW'(p);
      end
      if (has_norm[p] && tag_eq[p]) begin
        norm_hit  = 1'b1;
        norm_idx  = IW'(p);
        norm_half = (st[p][1] == ST_NORM);
      end
    end
  end
endmodule

// File: rtl/txc_alloc.sv
// Picks the pair for a new line: lowest fully invalid, else lowest ordinary.
module txc_alloc import txc_pkg::*; #(
  parameter int PAIRS = 4,
  parameter int IW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic [PAIRS-1:0][1:0][1:0] st,
  output logic                       alloc_ok,
  output logic [IW-1:0]              alloc_idx,
  output logic                       alloc_evict,
  output logic                       evict_half
);
  logic [PAIRS-1:0] is_empty, is_reclaim;

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign is_empty[g]   = (st[g][0] == ST_INV) && (st[g][1] == ST_INV);
    assign is_reclaim[g] = (st[g][0] == ST_NORM) || (st[g][1] == ST_NORM);
  end

  always_comb begin
    logic          e_found, r_found;
    logic [IW-1:0] e_idx, r_idx;
    logic          r_half;
    e_found = 1'b0;
    r_found = 1'b0;
    e_idx   = '0;
    r_idx   = '0;
    r_half  = 1'b0;
    for (int p = PAIRS - 1; p >= 0; p--) begin
      if (is_empty[p]) begin
        e_found = 1'b1;
        e_idx   = IW'(p);
      end
      if (is_reclaim[p]) begin
        r_found = 1'b1;
        r_idx   = IW'(p);
        r_half  = (st[p][1] == ST_NORM);
      end
    end
    alloc_ok    = e_found || r_found;
    alloc_idx   = e_found ? e_idx : r_idx;
    alloc_evict = !e_found && r_found;
    evict_half  = r_half;
  end
endmodule

// File: rtl/txc_retag.sv
// State rewrite of one entry on commit or abort.
module txc_retag import txc_pkg::*; (
  input  logic [1:0] cur,
  input  logic       commit_i,
  input  logic       abort_i,
  output logic [1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (commit_i) begin
      if (cur == ST_OLD)      nxt = ST_INV;
      else if (cur == ST_NEW) nxt = ST_NORM;
    end else if (abort_i) begin
      if (cur == ST_NEW)      nxt = ST_INV;
      else if (cur == ST_OLD) nxt = ST_NORM;
    end
  end
endmodule

// File: rtl/txc_dual_cache.sv
module txc_dual_cache import txc_pkg::*; #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int PAIRS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic [DW-1:0] op_fill,
  input  logic          own_nack,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [DW-1:0] rsp_data,
  input  logic          snp_valid,
  input  logic          snp_write,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_rsp_valid,
  output logic          snp_nack,
  output logic          evict_valid,
  output logic [AW-1:0] evict_addr,
  output logic [DW-1:0] evict_data,
  output logic          abort_pending
);
  localparam int IW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PAIRS-1:0][1:0][1:0] st_q, st_rt;
  logic [PAIRS-1:0][AW-1:0]   tag_q;
  logic [PAIRS-1:0]           wr_q;
  logic [DW-1:0]              data_q [PAIRS][2];

  // operation decode
  logic is_ld, is_st, op_ls, collide, ab_eff, do_cmt, do_abt, ls_go;
  assign is_ld   = op_valid && (op_kind == OP_LOAD);
  assign is_st   = op_valid && (op_kind == OP_STORE);
  assign op_ls   = is_ld || is_st;
  assign collide = op_ls && snp_valid && (snp_addr == op_addr);
  assign ab_eff  = abort_pending || own_nack;
  assign do_cmt  = op_valid && (op_kind == OP_COMMIT) && !ab_eff;
  assign do_abt  = op_valid && ((op_kind == OP_ABORT) ||
                                ((op_kind == OP_COMMIT) && ab_eff));
  assign ls_go   = op_ls && !collide && !ab_eff;

  // lookups
  logic          o_txn, o_norm, o_nhalf, s_txn, s_norm, s_nhalf;
  logic [IW-1:0] o_tidx, o_nidx, s_tidx, s_nidx;
  logic          a_ok, a_evict, a_ehalf;
  logic [IW-1:0] a_idx;

  txc_match #(.PAIRS(PAIRS), .AW(AW), .IW(IW)) op_match_i (
    .addr(op_addr), .tags(tag_q), .st(st_q),
    .txn_hit(o_txn), .txn_idx(o_tidx),
    .norm_hit(o_norm), .norm_idx(o_nidx), .norm_half(o_nhalf));

  txc_match #(.PAIRS(PAIRS), .AW(AW), .IW(IW)) snp_match_i (
    .addr(snp_addr), .tags(tag_q), .st(st_q),
    .txn_hit(s_txn), .txn_idx(s_tidx),
    .norm_hit(s_norm), .norm_idx(s_nidx), .norm_half(s_nhalf));

  txc_alloc #(.PAIRS(PAIRS), .IW(IW)) alloc_i (
    .st(st_q), .alloc_ok(a_ok), .alloc_idx(a_idx),
    .alloc_evict(a_evict), .evict_half(a_ehalf));

  for (genvar p = 0; p < PAIRS; p++) begin : g_rt
    for (genvar h = 0; h < 2; h++) begin : g_half
      txc_retag retag_i (
        .cur(st_q[p][h]), .commit_i(do_cmt), .abort_i(do_abt),
        .nxt(st_rt[p][h]));
    end
  end

  // derived controls
  logic          new_half, use_alloc, overflow, ok_ls, snp_conf, snp_inv;
  logic [DW-1:0] ld_val;
  assign new_half  = (st_q[o_tidx][1] == ST_NEW);
  assign use_alloc = !o_txn && !o_norm;
  assign overflow  = ls_go && use_alloc && !a_ok;
  assign ok_ls     = ls_go && !overflow;
  assign snp_conf  = snp_valid && s_txn && (snp_write || wr_q[s_tidx]);
  assign snp_inv   = snp_valid && snp_write && s_norm;

  always_comb begin
    if (is_st)       ld_val = op_wdata;
    else if (o_txn)  ld_val = data_q[o_tidx][new_half];
    else if (o_norm) ld_val = data_q[o_nidx][o_nhalf];
    else             ld_val = op_fill;
  end

  // state update
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= '0;
      wr_q          <= '0;
      abort_pending <= 1'b0;
    end else begin
      st_q <= st_rt;
      if (do_cmt || do_abt) wr_q <= '0;
      if (snp_inv) st_q[s_nidx][s_nhalf] <= ST_INV;
      if (ok_ls) begin
        if (o_txn) begin
          if (is_st) begin
            data_q[o_tidx][new_half] <= op_wdata;
            wr_q[o_tidx]             <= 1'b1;
          end
        end else if (o_norm) begin
          st_q[o_nidx][o_nhalf]    <= ST_OLD;
          st_q[o_nidx][!o_nhalf]   <= ST_NEW;
          data_q[o_nidx][!o_nhalf] <= ld_val;
          wr_q[o_nidx]             <= is_st;
        end else begin
          tag_q[a_idx]     <= op_addr;
          st_q[a_idx][0]   <= ST_OLD;
          st_q[a_idx][1]   <= ST_NEW;
          data_q[a_idx][0] <= op_fill;
          data_q[a_idx][1] <= ld_val;
          wr_q[a_idx]      <= is_st;
        end
      end
      abort_pending <= (do_cmt || do_abt) ? 1'b0 : (ab_eff || overflow);
    end
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_ok        <= 1'b0;
      rsp_data      <= '0;
      snp_rsp_valid <= 1'b0;
      snp_nack      <= 1'b0;
      evict_valid   <= 1'b0;
      evict_addr    <= '0;
      evict_data    <= '0;
    end else begin
      rsp_valid <= op_valid;
      if (op_ls)
        rsp_ok <= ok_ls;
      else if (op_kind == OP_COMMIT)
        rsp_ok <= do_cmt;
      else if (op_kind == OP_ABORT)
        rsp_ok <= 1'b1;
      else if (op_kind == OP_VALIDATE)
        rsp_ok <= !ab_eff;
      else
        rsp_ok <= 1'b0;
      rsp_data      <= ok_ls ? ld_val : '0;
      snp_rsp_valid <= snp_valid;
      snp_nack      <= snp_conf;
      evict_valid   <= ok_ls && use_alloc && a_evict;
      evict_addr    <= tag_q[a_idx];
      evict_data    <= data_q[a_idx][a_ehalf];
    end
  end
endmodule

// File: rtl/txc_checker.sv
module txc_checker import txc_pkg::*; #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [2:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic          own_nack,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic          snp_valid,
  input logic [AW-1:0] snp_addr,
  input logic          snp_rsp_valid,
  input logic          snp_nack,
  input logic          evict_valid,
  input logic          abort_pending
);
  // R7
  own_nack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (own_nack && !(op_valid && (op_kind == OP_COMMIT || op_kind == OP_ABORT)))
    |=> abort_pending);

  // R7
  pending_commit_fails_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_COMMIT && (abort_pending || own_nack)) |=> !rsp_ok);

  // R11
  abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_ABORT) |=> (!abort_pending && rsp_ok));

  // R8
  validate_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_VALIDATE) |=> (rsp_ok != $past(abort_pending || own_nack)));

  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_pending) |-> $past(own_nack || op_valid));

  // R10
  evict_chk: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> (rsp_valid && rsp_ok));

  // R6
  nack_chk: assert property (@(posedge clk) disable iff (rst)
    snp_nack |-> snp_rsp_valid);

  // R12
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_kind == OP_LOAD || op_kind == OP_STORE) && snp_valid &&
     (snp_addr == op_addr)) |=> !rsp_ok);
endmodule

bind txc_dual_cache txc_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .op_addr(op_addr), .own_nack(own_nack), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .snp_valid(snp_valid), .snp_addr(snp_addr),
  .snp_rsp_valid(snp_rsp_valid), .snp_nack(snp_nack),
  .evict_valid(evict_valid), .abort_pending(abort_pending));

// File: tb/txc_dual_cache_tb_top.sv
module txc_dual_cache_tb_top;
  localparam int AW = 8, DW = 16, P = 4;

  logic clk = 0, rst = 1;
  logic op_valid = 0, own_nack = 0, snp_valid = 0, snp_write = 0;
  logic [2:0] op_kind = 0;
  logic [AW-1:0] op_addr = 0, snp_addr = 0;
  logic [DW-1:0] op_wdata = 0, op_fill = 0;
  logic rsp_valid, rsp_ok, snp_rsp_valid, snp_nack, evict_valid, abort_pending;
  logic [DW-1:0] rsp_data, evict_data;
  logic [AW-1:0] evict_addr;

  always #5 clk = ~clk;

  txc_dual_cache #(.AW(AW), .DW(DW), .PAIRS(P)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_fill(op_fill),
    .own_nack(own_nack), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_data(rsp_data), .snp_valid(snp_valid), .snp_write(snp_write),
    .snp_addr(snp_addr), .snp_rsp_valid(snp_rsp_valid), .snp_nack(snp_nack),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .evict_data(evict_data), .abort_pending(abort_pending));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // line-level model: kind 0 empty, 1 ordinary, 2 transactional
  int            m_kind [P];
  logic [AW-1:0] m_tag  [P];
  logic [DW-1:0] m_old  [P];
  logic [DW-1:0] m_new  [P];
  logic [DW-1:0] m_nv   [P];
  bit            m_wr   [P];
  bit            m_ab;

  task automatic chk(input bit good, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < P; p++) begin
      m_kind[p] = 0; m_tag[p] = 0; m_wr[p] = 0;
      m_old[p] = 0; m_new[p] = 0; m_nv[p] = 0;
    end
    m_ab = 0;
  endtask

  task automatic step(input bit opv, input logic [2:0] k, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [DW-1:0] fl,
                      input bit nk, input bit snv, input bit snw,
                      input logic [AW-1:0] sna, input string rq);
    bit e_ok, e_ev, e_nack, abe, ovf;
    logic [DW-1:0] e_dat, e_evd;
    logic [AW-1:0] e_eva;
    int s_txn, s_norm, hit, sl;
    e_ok = 0; e_ev = 0; ovf = 0; e_dat = 0; e_evd = 0; e_eva = 0;
    s_txn = -1; s_norm = -1;
    for (int p = 0; p < P; p++)
      if (m_tag[p] == sna) begin
        if (m_kind[p] == 2) s_txn = p;
        else if (m_kind[p] == 1) s_norm = p;
      end
    e_nack = snv && (s_txn >= 0) && (snw || m_wr[s_txn >= 0 ? s_txn : 0]);
    abe = m_ab || nk;
    if (opv) begin
      if (k <= 3'd1) begin
        if (!(snv && sna == a) && !abe) begin
          hit = -1;
          for (int p = 0; p < P; p++) if (m_kind[p] == 2 && m_tag[p] == a) hit = p;
          if (hit >= 0) begin
            e_ok = 1;
            if (k == 3'd1) begin m_new[hit] = wd; m_wr[hit] = 1; e_dat = wd; end
            else e_dat = m_new[hit];
          end else begin
            sl = -1;
            for (int p = 0; p < P; p++) if (m_kind[p] == 1 && m_tag[p] == a) sl = p;
            if (sl >= 0) begin
              m_old[sl] = m_nv[sl];
              e_dat = (k == 3'd1) ? wd : m_nv[sl];
              m_new[sl] = e_dat;
            end else begin
              for (int p = P - 1; p >= 0; p--) if (m_kind[p] == 0) sl = p;
              if (sl < 0) begin
                for (int p = P - 1; p >= 0; p--) if (m_kind[p] == 1) sl = p;
                if (sl >= 0) begin e_ev = 1; e_eva = m_tag[sl]; e_evd = m_nv[sl]; end
              end
              if (sl >= 0) begin
                m_tag[sl] = a; m_old[sl] = fl;
                e_dat = (k == 3'd1) ? wd : fl;
                m_new[sl] = e_dat;
              end
            end
            if (sl >= 0) begin m_kind[sl] = 2; m_wr[sl] = (k == 3'd1); e_ok = 1; end
            else ovf = 1;
          end
        end
      end else if (k == 3'd2 || k == 3'd3) begin
        e_ok = (k == 3'd3) || !abe;
        for (int p = 0; p < P; p++) begin
          if (m_kind[p] == 2) begin
            m_kind[p] = 1;
            m_nv[p] = (k == 3'd2 && !abe) ? m_new[p] : m_old[p];
          end
          m_wr[p] = 0;
        end
      end else if (k == 3'd4) begin
        e_ok = !abe;
      end
    end
    if (opv && (k == 3'd2 || k == 3'd3)) m_ab = 0;
    else m_ab = abe || ovf;
    if (snv && snw && s_norm >= 0 && m_kind[s_norm] == 1 && m_tag[s_norm] == sna)
      m_kind[s_norm] = 0;

    @(negedge clk);
    op_valid = opv; op_kind = k; op_addr = a; op_wdata = wd; op_fill = fl;
    own_nack = nk; snp_valid = snv; snp_write = snw; snp_addr = sna;
    @(posedge clk);
    #1;
    if (opv) begin
      chk(rsp_valid == 1'b1, rq, "rsp_valid", 32'(rsp_valid), 1);
      chk(rsp_ok == e_ok, rq, "rsp_ok", 32'(rsp_ok), 32'(e_ok));
      if (e_ok && k <= 3'd1)
        chk(rsp_data == e_dat, rq, "rsp_data", 32'(rsp_data), 32'(e_dat));
      chk(evict_valid == e_ev, rq, "evict_valid", 32'(evict_valid), 32'(e_ev));
      if (e_ev) begin
        chk(evict_addr == e_eva, rq, "evict_addr", 32'(evict_addr), 32'(e_eva));
        chk(evict_data == e_evd, rq, "evict_data", 32'(evict_data), 32'(e_evd));
      end
    end
    if (snv) chk(snp_nack == e_nack, rq, "snp_nack", 32'(snp_nack), 32'(e_nack));
    chk(abort_pending == m_ab, rq, "abort_pending", 32'(abort_pending), 32'(m_ab));
  endtask

  task automatic op(input logic [2:0] k, input logic [AW-1:0] a,
                    input logic [DW-1:0] wd, input logic [DW-1:0] fl, input string rq);
    step(1, k, a, wd, fl, 0, 0, 0, 0, rq);
  endtask

  task automatic snoop(input bit w, input logic [AW-1:0] a, input string rq);
    step(0, 0, 0, 0, 0, 0, 1, w, a, rq);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(rsp_valid == 0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(snp_rsp_valid == 0, "R1", "snp_rsp_valid", 32'(snp_rsp_valid), 0);
    chk(evict_valid == 0, "R1", "evict_valid", 32'(evict_valid), 0);
    chk(abort_pending == 0, "R1", "abort_pending", 32'(abort_pending), 0);
    @(negedge clk); rst = 0;
    op(4, 0, 0, 0, "R8");

    // R2: miss returns fill, hit returns after image
    op(0, 8'h20, 0, 16'h0111, "R2");
    op(0, 8'h20, 0, 16'h0999, "R2");
    // R3: store then abort restores before image
    op(1, 8'h20, 16'h0222, 16'h0888, "R3");
    op(0, 8'h20, 0, 16'h0777, "R3");
    op(3, 0, 0, 0, "R11");
    op(0, 8'h20, 0, 16'h0555, "R3");
    // R4: commit keeps stored value
    op(1, 8'h20, 16'h0333, 16'h0000, "R4");
    op(2, 0, 0, 0, "R4");
    op(0, 8'h20, 0, 16'h0777, "R4");
    op(3, 0, 0, 0, "R11");
    // R6: snoop conflicts
    op(0, 8'h30, 0, 16'h0abc, "R6");
    op(1, 8'h31, 16'h0def, 16'h0123, "R6");
    snoop(0, 8'h30, "R6");
    snoop(0, 8'h31, "R6");
    snoop(1, 8'h30, "R6");
    snoop(0, 8'h40, "R6");
    snoop(0, 8'h20, "R6");
    op(3, 0, 0, 0, "R11");
    // R9: snoop write drops ordinary line
    snoop(1, 8'h20, "R9");
    op(0, 8'h20, 0, 16'h0444, "R9");
    op(3, 0, 0, 0, "R11");
    // R12: collision leaves state untouched
    op(1, 8'h30, 16'h5555, 0, "R12");
    step(1, 1, 8'h30, 16'h6666, 0, 0, 1, 0, 8'h30, "R12");
    op(0, 8'h30, 0, 16'h0fff, "R12");
    op(2, 0, 0, 0, "R4");
    // R10 / R5: fill, commit, evict, overflow
    for (int i = 0; i < 4; i++) op(1, 8'h50 + 8'(i), 16'h1000 + 16'(i), 16'h0, "R10");
    op(2, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) op(0, 8'h70 + 8'(i), 0, 16'h2000 + 16'(i), "R10");
    op(0, 8'h74, 0, 16'h2222, "R5");
    op(4, 0, 0, 0, "R8");
    op(1, 8'h70, 16'h7777, 0, "R7");
    op(2, 0, 0, 0, "R7");
    op(4, 0, 0, 0, "R8");
    // R7: own request refused
    op(1, 8'h70, 16'h3131, 0, "R7");
    step(1, 4, 0, 0, 0, 1, 0, 0, 0, "R7");
    op(0, 8'h70, 0, 0, "R7");
    op(2, 0, 0, 0, "R7");
    op(0, 8'h70, 0, 16'h0bad, "R7");
    op(3, 0, 0, 0, "R11");

    // constrained random phase
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit opv, nk, snv, snw;
      logic [2:0] k;
      r = int'($urandom % 100);
      opv = 1;
      if (r < 35) k = 0;
      else if (r < 70) k = 1;
      else if (r < 78) k = 2;
      else if (r < 85) k = 3;
      else if (r < 92) k = 4;
      else begin k = 0; opv = 0; end
      nk  = ($urandom % 40) == 0;
      snv = ($urandom % 4) == 0;
      snw = $urandom % 2;
      step(opv, k, 8'h10 + 8'($urandom % 6), 16'($urandom), 16'($urandom),
           nk, snv, snw, 8'h10 + 8'($urandom % 6), "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule